// File: doc/BRIEF.md
# Dual-Counter Carry/Borrow Loop Filter

This block is the loop filter of an all-digital phase-locked loop. A phase detector hands it a one-bit direction level (`dn_up`). It hands a digitally controlled oscillator two kinds of single-cycle steering pulse: `carry_pulse` asks the oscillator to insert half a cycle, and `borrow_pulse` asks it to remove one. Everything runs on one system clock. The slow counting clock arrives as a strobe, `kclk_en`, that marks each active (falling) edge of that clock. A second input, `count_en`, can freeze counting for ripple-cancellation schemes.

Inside there are two up-only counters modulo K, one per direction. On each qualified tick the direction level picks the counter that advances: low advances the up counter and high advances the down counter. Each counter has a threshold level that is high while its contents lie in the upper half of the range [K/2, K-1]. A small rise-detect state machine per channel turns the rising edge of that level into one registered pulse. K is a power of two, 2^`k_exp`. The exponent is captured only while the synchronous reset is asserted, and it is clamped to the range 3..15.

Each rise-detect machine has three states. `EDGE_WAIT` means the level is low. `EDGE_FIRE` is the single cycle in which the pulse is driven. `EDGE_HOLD` means the level is high and the pulse has already been issued. The transitions are:
- WAIT→FIRE on a high level.
- FIRE→HOLD on a high level.
- FIRE→WAIT on a low level.
- HOLD→WAIT on a low level.
- Otherwise the state holds.

Reset forces `EDGE_WAIT`.

Top module: `dual_count_loop_filter`

## Requirements
- R1: On a qualified tick (`kclk_en`=1 and `count_en`=1), `dn_up`=0 advances only the up counter and `dn_up`=1 advances only the down counter. Both counters only ever increment.
- R2: Each counter cycles 0..K-1 and wraps to 0. Under continuous advances of one direction, its pulse recurs exactly every K ticks.
- R3: The carry level is high while the up counter holds a value of at least K/2. Starting from 0, `carry_pulse` is therefore raised by the K/2-th up advance.
- R4: The borrow level is high while the down counter holds a value of at least K/2. Starting from 0, `borrow_pulse` is therefore raised by the K/2-th down advance.
- R5: A pulse appears only on a rising edge of its threshold level. It is exactly one system-clock cycle wide, and the two pulses are never high together.
- R6: When `kclk_en`=0 or `count_en`=0, neither counter advances, so no pulse timing moves.
- R7: K = 2^e. Here e is `k_exp` sampled during reset and clamped to the range 3..15, so values 0..2 give K=8. Changing `k_exp` outside reset has no effect.
- R8: Synchronous reset (`rst`=1) clears both counters and both rise-detect machines. Both pulses are low in the cycle after reset.
- R9: A pulse is high during the second clock cycle after the edge on which the crossing advance is sampled, that is, one cycle after the counter takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also captures `k_exp` |
| kclk_en | input | 1 | One-cycle strobe marking each active edge of the counting clock |
| dn_up | input | 1 | Phase-detector direction: 0 advances the up counter, 1 advances the down counter |
| count_en | input | 1 | Counting enable; low freezes both counters |
| k_exp | input | 4 | Modulus exponent, K = 2^k_exp, clamped to 3..15 |
| carry_pulse | output | 1 | One-cycle pulse when the up counter enters its upper half |
| borrow_pulse | output | 1 | One-cycle pulse when the down counter enters its upper half |

## Verification
A counter holding a wrong value shows at the ports as a carry or borrow pulse shifted in time. The error is visible no later than K qualified ticks in that direction, because every wrap back through the half-way point produces an observable pulse. A rise-detect machine stuck in the wrong state shows within one threshold crossing, either as a missing pulse, a pulse wider than one cycle, or a pulse with no crossing behind it. A wrongly captured modulus changes the pulse spacing at the first pulse after reset. The bench predicts every cycle of both outputs from an arithmetic model across several moduli, pseudo-random direction and enable patterns, and one long run at the largest modulus.

// File: rtl/lfilt_pkg.sv
package lfilt_pkg;

    typedef enum logic [1:0] {
        EDGE_WAIT = 2'd0,
        EDGE_FIRE = 2'd1,
        EDGE_HOLD = 2'd2
    } edge_state_e;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_UP  = 0;
    localparam int unsigned DIR_DN  = 1;

endpackage

// File: rtl/kmod_config.sv
module kmod_config #(
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned CW      = 15,
    parameter int unsigned MIN_EXP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] k_exp_in,
    output logic [CW-1:0]    wrap_mask,
    output logic [CW-1:0]    half_val
);

    localparam logic [EXP_W-1:0] MIN_E = EXP_W'(MIN_EXP);
    localparam logic [EXP_W-1:0] MAX_E = EXP_W'(CW);

    logic [EXP_W-1:0] exp_q;
    logic [EXP_W-1:0] exp_clamped;

    always_comb begin
        if (k_exp_in < MIN_E)
            exp_clamped = MIN_E;
        else if (k_exp_in > MAX_E)
            exp_clamped = MAX_E;
        else
            exp_clamped = k_exp_in;
    end

    // Exponent is only captured while reset is held
    always_ff @(posedge clk) begin
        if (rst)
            exp_q <= exp_clamped;
    end

    for (genvar b = 0; b < CW; b++) begin : g_bits
        assign wrap_mask[b] = (EXP_W'(b) < exp_q);
        assign half_val[b]  = (EXP_W'(b + 1) == exp_q);
    end

    // R7: modulus frozen outside reset
    a_r7_exp_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(exp_q));

    // R7: captured exponent always inside the legal range
    a_r7_exp_range: assert property (@(posedge clk) disable iff (rst)
        (exp_q >= MIN_E) && (exp_q <= MAX_E));

endmodule

// File: rtl/dir_counter.sv
module dir_counter #(
    parameter int unsigned CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [CW-1:0] wrap_mask,
    input  logic [CW-1:0] half_val,
    output logic [CW-1:0] count,
    output logic          level
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (advance)
            count <= (count + 1'b1) & wrap_mask;
    end

    assign level = (count >= half_val);

    // R2: contents never leave 0..K-1
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        count <= wrap_mask);

    // R1: an advance always moves the contents (K >= 8)
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        advance |=> count != $past(count));

    // R6: no advance, no movement
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count));

endmodule

// File: rtl/rise_pulse_fsm.sv
module rise_pulse_fsm
    import lfilt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);

    edge_state_e state_q;
    edge_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= EDGE_WAIT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_WAIT: if (level)  state_d = EDGE_FIRE;
            EDGE_FIRE: state_d = level ? EDGE_HOLD : EDGE_WAIT;
            EDGE_HOLD: if (!level) state_d = EDGE_WAIT;
            default:   state_d = EDGE_WAIT;
        endcase
    end

    always_comb begin
        pulse = (state_q == EDGE_FIRE);
    end

    // R5: pulse lasts a single cycle
    a_r5_single: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R5: pulse is preceded by a high threshold level
    a_r5_from_level: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(level));

endmodule

// File: rtl/dual_count_loop_filter.sv
module dual_count_loop_filter
    import lfilt_pkg::*;
#(
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned MAX_EXP = 15,
    parameter int unsigned MIN_EXP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kclk_en,
    input  logic             dn_up,
    input  logic             count_en,
    input  logic [EXP_W-1:0] k_exp,
    output logic             carry_pulse,
    output logic             borrow_pulse
);

    localparam int unsigned CW = MAX_EXP;

    logic [CW-1:0] wrap_mask;
    logic [CW-1:0] half_val;
    logic          tick;
    logic [CW-1:0] cnt   [NUM_DIR];
    logic          adv   [NUM_DIR];
    logic          lvl   [NUM_DIR];
    logic          pulse [NUM_DIR];

    kmod_config #(
        .EXP_W   (EXP_W),
        .CW      (CW),
        .MIN_EXP (MIN_EXP)
    ) u_kcfg (
        .clk       (clk),
        .rst       (rst),
        .k_exp_in  (k_exp),
        .wrap_mask (wrap_mask),
        .half_val  (half_val)
    );

    assign tick = kclk_en & count_en;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        if (d == DIR_DN) begin : g_sel_dn
            assign adv[d] = tick & dn_up;
        end else begin : g_sel_up
            assign adv[d] = tick & ~dn_up;
        end

        dir_counter #(
            .CW (CW)
        ) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .advance   (adv[d]),
            .wrap_mask (wrap_mask),
            .half_val  (half_val),
            .count     (cnt[d]),
            .level     (lvl[d])
        );

        rise_pulse_fsm u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (lvl[d]),
            .pulse (pulse[d])
        );
    end

    assign carry_pulse  = pulse[DIR_UP];
    assign borrow_pulse = pulse[DIR_DN];

    // R1: an up tick leaves the down counter untouched
    a_r1_up_only: assert property (@(posedge clk) disable iff (rst)
        (kclk_en && count_en && !dn_up) |=> $stable(cnt[DIR_DN]));

    // R1: a down tick leaves the up counter untouched
    a_r1_dn_only: assert property (@(posedge clk) disable iff (rst)
        (kclk_en && count_en && dn_up) |=> $stable(cnt[DIR_UP]));

    // R6: gated ticks freeze both counters
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        !(kclk_en && count_en) |=> ($stable(cnt[DIR_UP]) && $stable(cnt[DIR_DN])));

    // R5: carry and borrow never coincide
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(carry_pulse && borrow_pulse));

endmodule

// File: tb/dual_count_loop_filter_tb_top.sv
module dual_count_loop_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk_en = 1'b0;
    logic       dn_up = 1'b0;
    logic       count_en = 1'b0;
    logic [3:0] k_exp = 4'd3;
    logic       carry_pulse;
    logic       borrow_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    int  k_m = 8;
    int  up_m = 0, dn_m = 0;
    bit  prev_c = 0, prev_b = 0;
    bit  exp_c = 0, exp_b = 0;
    int  seen_c = 0, seen_b = 0;

    always #4 clk = ~clk;

    dual_count_loop_filter dut_i (
        .clk          (clk),
        .rst          (rst),
        .kclk_en      (kclk_en),
        .dn_up        (dn_up),
        .count_en     (count_en),
        .k_exp        (k_exp),
        .carry_pulse  (carry_pulse),
        .borrow_pulse (borrow_pulse)
    );

    task automatic check_int(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic do_reset(input logic [3:0] e);
        @(negedge clk);
        rst = 1'b1; k_exp = e; kclk_en = 0; count_en = 0; dn_up = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k_m = 1 << ((e < 3) ? 3 : e);
        up_m = 0; dn_m = 0; prev_c = 0; prev_b = 0; exp_c = 0; exp_b = 0;
        @(posedge clk);
        @(negedge clk);
        check_int("R8 carry after reset", carry_pulse, 0);
        check_int("R8 borrow after reset", borrow_pulse, 0);
    endtask

    // One cycle: drive, model the edge, compare away from the edge (R9 latency)
    task automatic step(input bit d, input bit en, input bit kce, input string tag);
        bit lc, lb;
        dn_up = d; count_en = en; kclk_en = kce;
        @(posedge clk);
        lc = (up_m >= k_m / 2);
        lb = (dn_m >= k_m / 2);
        exp_c = lc && !prev_c;
        exp_b = lb && !prev_b;
        prev_c = lc; prev_b = lb;
        if (kce && en) begin
            if (d) dn_m = (dn_m + 1) % k_m;
            else   up_m = (up_m + 1) % k_m;
        end
        @(negedge clk);
        check_int({tag, " carry"}, carry_pulse, int'(exp_c));
        check_int({tag, " borrow"}, borrow_pulse, int'(exp_b));
        if (carry_pulse) seen_c++;
        if (borrow_pulse) seen_b++;
    endtask

    task automatic lfsr_sweep(input int n, input string tag);
        logic [15:0] r = 16'hACE1;
        for (int i = 0; i < n; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            step(r[0], r[1] | r[2], r[3] | r[4], tag);
        end
    endtask

    initial begin
        // R8: reset state
        do_reset(4'd3);

        // R3 / R9: first carry after K/2 up advances, one cycle late
        for (int i = 0; i < 3 * 8 + 2; i++) step(1'b0, 1'b1, 1'b1, "R3");
        check_int("R2 carries in three wraps", seen_c, 3);

        // R4: borrow after K/2 down advances
        seen_b = 0;
        for (int i = 0; i < 8 + 2; i++) step(1'b1, 1'b1, 1'b1, "R4");
        check_int("R4 borrow count", seen_b, 1);

        // R6: gated ticks produce no movement
        seen_c = 0; seen_b = 0;
        for (int i = 0; i < 40; i++) step(i[0], 1'b0, 1'b1, "R6 count_en low");
        for (int i = 0; i < 40; i++) step(i[0], 1'b1, 1'b0, "R6 kclk_en low");
        check_int("R6 no pulses while gated", seen_c + seen_b, 0);

        // R1 / R5 / R6: mixed patterns
        lfsr_sweep(2000, "R1 mix K8");

        // R7: exponent change outside reset is ignored (model keeps K=8)
        k_exp = 4'd4;
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, "R7 no effect");

        // R7: new K=16 after reset
        do_reset(4'd4);
        seen_c = 0;
        for (int i = 0; i < 33; i++) step(1'b0, 1'b1, 1'b1, "R2 K16");
        check_int("R2 K16 carries", seen_c, 2);
        lfsr_sweep(2000, "R5 mix K16");

        // R7: exponent below minimum clamps to K=8
        do_reset(4'd1);
        seen_c = 0;
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, "R7 clamp");
        check_int("R7 clamp carries", seen_c, 1);

        // R4 at the largest modulus
        do_reset(4'd15);
        seen_b = 0;
        for (int i = 0; i < 16384 + 3; i++) step(1'b1, 1'b1, 1'b1, "R4 K32768");
        check_int("R4 K32768 borrow count", seen_b, 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule